// File: doc/BRIEF.md
# SHA-512 Compression Core

This block computes one SHA-512 compression step. A caller presents a 512-bit chaining value and a 1024-bit message block, then asserts a start strobe. The core captures both values in a single cycle and runs the 80 rounds at one round per clock. The message schedule is expanded on the fly from a 16-word window. Each output word is the final working register added, modulo 2^64, to the chaining word that was captured at the start. When the result is ready, a one-cycle completion pulse is raised. The result then stays on its output until the next operation finishes.

The core has no padding, no length encoding and no multi-block sequencing. An enclosing mode, such as a keyed authenticated-encryption construction, supplies every chaining value itself and feeds each result back in. For plain hashing, the standard initial chaining value is available as a package constant, `INIT_CHAIN`.

Top module: `sha512_compress`

## Requirements
- R1: While reset is asserted and immediately after it, `busy_o` and `done_o` are 0 and `digest_o` is all zeros.
- R2: Word j (j = 0 for the first word) of `chain_i`, `block_i` and `digest_o` occupies bits [64j+63:64j]. Message word 0 is the schedule word of round 0.
- R3: `digest_o` word j equals working register j after 80 rounds plus chaining word j, modulo 2^64. The rounds use the SHA-512 round function, the SHA-512 message expansion and the 80 round constants, which are the fractional parts of the cube roots of the first 80 primes.
- R4: A start seen while idle is accepted at that clock edge, and `busy_o` is 1 from the next cycle. `done_o` rises after the 82nd rising edge, counting the accepting edge as the first: one load cycle, 80 round cycles and one finalize cycle.
- R5: `done_o` stays high for exactly one cycle. In that cycle `busy_o` is already 0.
- R6: A start asserted while `busy_o` is 1 is ignored, including in the finalize cycle. The running result is unchanged and no second operation follows.
- R7: `digest_o` holds its value from one completion until the next completion, whatever the inputs do in between.
- R8: `chain_i` and `block_i` are sampled only at the accepting edge. Changing them later has no effect on the result.
- R9: A start asserted in the cycle where `done_o` is high is accepted, so operations can run back to back.
- R10: Word j of `INIT_CHAIN` equals the first 64 fractional bits of the square root of the (j+1)-th prime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| start_i | input | 1 | Request to begin a compression; honoured only while idle |
| chain_i | input | 512 | Chaining value, eight 64-bit words |
| block_i | input | 1024 | Message block, sixteen 64-bit words |
| busy_o | output | 1 | High from the cycle after acceptance through the finalize cycle |
| done_o | output | 1 | One-cycle pulse when a new result is on `digest_o` |
| digest_o | output | 512 | Compression result, eight 64-bit words |

## Verification
The assertions assume that `start_i` is a known level once the internal reset has been released. They also assume that the reset input is held low long enough to clear the synchronizer. They make no assumption about the data inputs, since those words matter only at the accepting edge. The bench drives every input to defined values from time zero and changes them only on falling clock edges. After each acceptance it deliberately scrambles the data inputs and pulses start at chosen round positions, including the finalize cycle. This exercises the ignore and hold rules inside the legal input space rather than relying on quiet inputs.

// File: rtl/sha512_pkg.sv
package sha512_pkg;

  localparam int WORD_W      = 64;
  localparam int STATE_WORDS = 8;
  localparam int MSG_WORDS   = 16;
  localparam int ROUNDS      = 80;
  localparam int CNT_W       = $clog2(ROUNDS);
  localparam int CHAIN_W     = WORD_W * STATE_WORDS;
  localparam int BLOCK_W     = WORD_W * MSG_WORDS;

  typedef logic [WORD_W-1:0]            word_t;
  typedef word_t [STATE_WORDS-1:0]      state_t;
  typedef word_t [MSG_WORDS-1:0]        window_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_FINAL = 2'd2
  } phase_t;

  // Standard starting chaining value for plain hashing, word 0 in the low bits.
  localparam state_t INIT_CHAIN = {
    64'h5be0cd19137e2179, 64'h1f83d9abfb41bd6b,
    64'h9b05688c2b3e6c1f, 64'h510e527fade682d1,
    64'ha54ff53a5f1d36f1, 64'h3c6ef372fe94f82b,
    64'hbb67ae8584caa73b, 64'h6a09e667f3bcc908
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t lit_sig0(input word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t lit_sig1(input word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

endpackage

// File: rtl/sha512_rst_sync.sv
module sha512_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sha512_k_rom.sv
module sha512_k_rom
  import sha512_pkg::*;
(
  input  logic [CNT_W-1:0] idx_i,
  output word_t            k_o
);

  localparam int HALF = ROUNDS / 2;

  logic [CNT_W-1:0] off_hi;
  word_t            k_lo;
  word_t            k_hi;

  assign off_hi = idx_i - CNT_W'(HALF);

  always_comb begin
    case (idx_i)
      7'd0:  k_lo = 64'h428a2f98d728ae22;  7'd1:  k_lo = 64'h7137449123ef65cd;
      7'd2:  k_lo = 64'hb5c0fbcfec4d3b2f;  7'd3:  k_lo = 64'he9b5dba58189dbbc;
      7'd4:  k_lo = 64'h3956c25bf348b538;  7'd5:  k_lo = 64'h59f111f1b605d019;
      7'd6:  k_lo = 64'h923f82a4af194f9b;  7'd7:  k_lo = 64'hab1c5ed5da6d8118;
      7'd8:  k_lo = 64'hd807aa98a3030242;  7'd9:  k_lo = 64'h12835b0145706fbe;
      7'd10: k_lo = 64'h243185be4ee4b28c;  7'd11: k_lo = 64'h550c7dc3d5ffb4e2;
      7'd12: k_lo = 64'h72be5d74f27b896f;  7'd13: k_lo = 64'h80deb1fe3b1696b1;
      7'd14: k_lo = 64'h9bdc06a725c71235;  7'd15: k_lo = 64'hc19bf174cf692694;
      7'd16: k_lo = 64'he49b69c19ef14ad2;  7'd17: k_lo = 64'hefbe4786384f25e3;
      7'd18: k_lo = 64'h0fc19dc68b8cd5b5;  7'd19: k_lo = 64'h240ca1cc77ac9c65;
      7'd20: k_lo = 64'h2de92c6f592b0275;  7'd21: k_lo = 64'h4a7484aa6ea6e483;
      7'd22: k_lo = 64'h5cb0a9dcbd41fbd4;  7'd23: k_lo = 64'h76f988da831153b5;
      7'd24: k_lo = 64'h983e5152ee66dfab;  7'd25: k_lo = 64'ha831c66d2db43210;
      7'd26: k_lo = 64'hb00327c898fb213f;  7'd27: k_lo = 64'hbf597fc7beef0ee4;
      7'd28: k_lo = 64'hc6e00bf33da88fc2;  7'd29: k_lo = 64'hd5a79147930aa725;
      7'd30: k_lo = 64'h06ca6351e003826f;  7'd31: k_lo = 64'h142929670a0e6e70;
      7'd32: k_lo = 64'h27b70a8546d22ffc;  7'd33: k_lo = 64'h2e1b21385c26c926;
      7'd34: k_lo = 64'h4d2c6dfc5ac42aed;  7'd35: k_lo = 64'h53380d139d95b3df;
      7'd36: k_lo = 64'h650a73548baf63de;  7'd37: k_lo = 64'h766a0abb3c77b2a8;
      7'd38: k_lo = 64'h81c2c92e47edaee6;  7'd39: k_lo = 64'h92722c851482353b;
      default: k_lo = '0;
    endcase
  end

  always_comb begin
    case (off_hi)
      7'd0:  k_hi = 64'ha2bfe8a14cf10364;  7'd1:  k_hi = 64'ha81a664bbc423001;
      7'd2:  k_hi = 64'hc24b8b70d0f89791;  7'd3:  k_hi = 64'hc76c51a30654be30;
      7'd4:  k_hi = 64'hd192e819d6ef5218;  7'd5:  k_hi = 64'hd69906245565a910;
      7'd6:  k_hi = 64'hf40e35855771202a;  7'd7:  k_hi = 64'h106aa07032bbd1b8;
      7'd8:  k_hi = 64'h19a4c116b8d2d0c8;  7'd9:  k_hi = 64'h1e376c085141ab53;
      7'd10: k_hi = 64'h2748774cdf8eeb99;  7'd11: k_hi = 64'h34b0bcb5e19b48a8;
      7'd12: k_hi = 64'h391c0cb3c5c95a63;  7'd13: k_hi = 64'h4ed8aa4ae3418acb;
      7'd14: k_hi = 64'h5b9cca4f7763e373;  7'd15: k_hi = 64'h682e6ff3d6b2b8a3;
      7'd16: k_hi = 64'h748f82ee5defb2fc;  7'd17: k_hi = 64'h78a5636f43172f60;
      7'd18: k_hi = 64'h84c87814a1f0ab72;  7'd19: k_hi = 64'h8cc702081a6439ec;
      7'd20: k_hi = 64'h90befffa23631e28;  7'd21: k_hi = 64'ha4506cebde82bde9;
      7'd22: k_hi = 64'hbef9a3f7b2c67915;  7'd23: k_hi = 64'hc67178f2e372532b;
      7'd24: k_hi = 64'hca273eceea26619c;  7'd25: k_hi = 64'hd186b8c721c0c207;
      7'd26: k_hi = 64'heada7dd6cde0eb1e;  7'd27: k_hi = 64'hf57d4f7fee6ed178;
      7'd28: k_hi = 64'h06f067aa72176fba;  7'd29: k_hi = 64'h0a637dc5a2c898a6;
      7'd30: k_hi = 64'h113f9804bef90dae;  7'd31: k_hi = 64'h1b710b35131c471b;
      7'd32: k_hi = 64'h28db77f523047d84;  7'd33: k_hi = 64'h32caab7b40c72493;
      7'd34: k_hi = 64'h3c9ebe0a15c9bebc;  7'd35: k_hi = 64'h431d67c49c100d4c;
      7'd36: k_hi = 64'h4cc5d4becb3e42b6;  7'd37: k_hi = 64'h597f299cfc657e2a;
      7'd38: k_hi = 64'h5fcb6fab3ad6faec;  7'd39: k_hi = 64'h6c44198c4a475817;
      default: k_hi = '0;
    endcase
  end

  assign k_o = (idx_i < CNT_W'(HALF)) ? k_lo : k_hi;

endmodule

// File: rtl/sha512_sched.sv
module sha512_sched
  import sha512_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_i,
  input  logic    shift_i,
  input  window_t block_i,
  output word_t   w_o
);

  window_t win_q;
  window_t win_d;
  word_t   w_new;
  logic    win_en;

  // Next schedule word from the current 16-word window (W_t .. W_t+15).
  assign w_new = lit_sig1(win_q[MSG_WORDS-2]) + win_q[MSG_WORDS-7]
               + lit_sig0(win_q[1]) + win_q[0];

  assign win_en = load_i | shift_i;

  always_comb begin
    if (load_i) begin
      win_d = block_i;
    end else begin
      for (int i = 0; i < MSG_WORDS - 1; i++) begin
        win_d[i] = win_q[i+1];
      end
      win_d[MSG_WORDS-1] = w_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  assign w_o = win_q[0];

  AST_SCHED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (w_o == $past(block_i[0]))); // R2

  AST_SCHED_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (w_o == $past(win_q[1]))); // R3

  AST_SCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> $stable(w_o)); // R8

endmodule

// File: rtl/sha512_round.sv
module sha512_round
  import sha512_pkg::*;
(
  input  state_t cur_i,
  input  word_t  k_i,
  input  word_t  w_i,
  output state_t nxt_o
);

  word_t t_one;
  word_t t_two;

  // Register order: 0=a 1=b 2=c 3=d 4=e 5=f 6=g 7=h
  assign t_one = cur_i[7] + big_sig1(cur_i[4])
               + f_choose(cur_i[4], cur_i[5], cur_i[6]) + k_i + w_i;
  assign t_two = big_sig0(cur_i[0]) + f_major(cur_i[0], cur_i[1], cur_i[2]);

  always_comb begin
    for (int i = 1; i < STATE_WORDS; i++) begin
      nxt_o[i] = cur_i[i-1];
    end
    nxt_o[0] = t_one + t_two;
    nxt_o[4] = cur_i[3] + t_one;
  end

endmodule

// File: rtl/sha512_compress.sv
module sha512_compress
  import sha512_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CHAIN_W-1:0] chain_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CHAIN_W-1:0] digest_o
);

  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  logic             srst_n;
  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  state_t           work_q, work_d;
  state_t           chain_q;
  state_t           digest_q;
  state_t           round_nxt;
  state_t           fin_sum;
  logic             done_q;
  logic             accept, in_round, in_final;
  logic             work_en, cnt_en;
  word_t            k_cur, w_cur;

  sha512_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  sha512_k_rom u_k_rom (
    .idx_i (cnt_q),
    .k_o   (k_cur)
  );

  sha512_sched u_sched (
    .clk     (clk),
    .rst_n   (srst_n),
    .load_i  (accept),
    .shift_i (in_round),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  sha512_round u_round (
    .cur_i (work_q),
    .k_i   (k_cur),
    .w_i   (w_cur),
    .nxt_o (round_nxt)
  );

  for (genvar j = 0; j < STATE_WORDS; j++) begin : g_final_add
    assign fin_sum[j] = work_q[j] + chain_q[j];
  end

  assign accept   = (phase_q == ST_IDLE) && start_i;
  assign in_round = (phase_q == ST_ROUND);
  assign in_final = (phase_q == ST_FINAL);
  assign work_en  = accept | in_round;
  assign cnt_en   = accept | in_round;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      ST_IDLE:  if (start_i) phase_d = ST_ROUND;
      ST_ROUND: if (cnt_q == LAST_RND) phase_d = ST_FINAL;
      ST_FINAL: phase_d = ST_IDLE;
      default:  phase_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d  = accept ? '0 : (cnt_q + 1'b1);
    work_d = accept ? state_t'(chain_i) : round_nxt;
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= in_final;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      chain_q <= '0;
    end else if (accept) begin
      chain_q <= chain_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      digest_q <= '0;
    end else if (in_final) begin
      digest_q <= fin_sum;
    end
  end

  assign busy_o   = (phase_q != ST_IDLE);
  assign done_o   = done_q;
  assign digest_o = digest_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_o && start_i) |=> busy_o); // R4

  AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!srst_n)
    in_round |-> (cnt_q <= LAST_RND)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |=> !done_o); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |-> !busy_o); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_o && start_i) |=> $stable(chain_q)); // R6

  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !done_o |-> $stable(digest_o)); // R7

endmodule

// File: tb/sha512_compress_tb.sv
module sha512_compress_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 82;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [511:0]  chain_i;
  logic [1023:0] block_i;
  logic          busy_o;
  logic          done_o;
  logic [511:0]  digest_o;

  int n_vec;
  int n_bad;
  bit finished;

  logic [63:0] kt [80];
  int          primes [80];

  sha512_compress u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .chain_i  (chain_i),
    .block_i  (block_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .digest_o (digest_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    summary();
  end

  // ---------------- reference arithmetic ----------------
  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [511:0] ref_compress(input logic [511:0] h, input logic [1023:0] m);
    logic [63:0] w [80];
    logic [63:0] v [8];
    logic [63:0] t1, t2, s0, s1, chv, mjv;
    logic [511:0] res;
    for (int t = 0; t < 16; t++) w[t] = m[64*t +: 64];
    for (int t = 16; t < 80; t++) begin
      s0 = rr(w[t-15], 1) ^ rr(w[t-15], 8) ^ (w[t-15] >> 7);
      s1 = rr(w[t-2], 19) ^ rr(w[t-2], 61) ^ (w[t-2] >> 6);
      w[t] = s1 + w[t-7] + s0 + w[t-16];
    end
    for (int i = 0; i < 8; i++) v[i] = h[64*i +: 64];
    for (int t = 0; t < 80; t++) begin
      chv = (v[4] & v[5]) ^ (~v[4] & v[6]);
      mjv = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
      t1 = v[7] + (rr(v[4], 14) ^ rr(v[4], 18) ^ rr(v[4], 41)) + chv + kt[t] + w[t];
      t2 = (rr(v[0], 28) ^ rr(v[0], 34) ^ rr(v[0], 39)) + mjv;
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[64*i +: 64] = v[i] + h[64*i +: 64];
    return res;
  endfunction

  task automatic build_tables();
    int cand;
    int cnt;
    logic [255:0] nn, root, trial;
    cnt = 0;
    cand = 2;
    while (cnt < 80) begin
      bit is_p;
      is_p = 1'b1;
      for (int d = 2; d * d <= cand; d++) if (cand % d == 0) is_p = 1'b0;
      if (is_p) begin primes[cnt] = cand; cnt++; end
      cand++;
    end
    for (int i = 0; i < 80; i++) begin
      nn = 256'(primes[i]) << 192;
      root = '0;
      for (int b = 66; b >= 0; b--) begin
        trial = root | (256'(1) << b);
        if (trial * trial * trial <= nn) root = trial;
      end
      kt[i] = root[63:0];
    end
  endtask

  function automatic logic [63:0] sqrt_frac(input int p);
    logic [255:0] nn, root, trial;
    nn = 256'(p) << 128;
    root = '0;
    for (int b = 66; b >= 0; b--) begin
      trial = root | (256'(1) << b);
      if (trial * trial <= nn) root = trial;
    end
    return root[63:0];
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  // Runs one operation; returns at the falling edge where done_o is seen.
  // poke: cycle index at which a start is pulsed while busy (0 = none).
  task automatic run_op(input logic [511:0] h, input logic [1023:0] m, input int poke,
                        input logic [511:0] prev, input string tag, output logic [511:0] exp);
    int  lat;
    bit  busy_bad, hold_bad;
    exp = ref_compress(h, m);
    chain_i = h; block_i = m; start_i = 1'b1;
    lat = 0; busy_bad = 1'b0; hold_bad = 1'b0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done_o) break;
      if (!busy_o) busy_bad = 1'b1;
      if (digest_o !== prev) hold_bad = 1'b1;
      start_i = (lat == poke);
      chain_i = ~h;
      block_i = {m[511:0], ~m[1023:512]};
    end
    start_i = 1'b0;
    check({tag, " R4 latency"}, 512'(lat), 512'(LATENCY));
    check({tag, " R4 busy while running"}, 512'(busy_bad), 512'(0));
    check({tag, " R7 digest held during run"}, 512'(hold_bad), 512'(0));
    check({tag, " R5 busy low at done"}, 512'(busy_o), 512'(0));
    check({tag, " R3 R8 digest"}, digest_o, exp);
  endtask

  // Idle cycles after a completion with inputs churning.
  task automatic idle_after(input logic [511:0] exp, input int cycles, input string tag);
    for (int c = 0; c < cycles; c++) begin
      chain_i = rnd512();
      block_i = {rnd512(), rnd512()};
      @(negedge clk);
      if (c == 0) check({tag, " R5 done single cycle"}, 512'(done_o), 512'(0));
      check({tag, " R6 no second run"}, 512'(busy_o), 512'(0));
      check({tag, " R7 digest holds"}, digest_o, exp);
    end
  endtask

  initial begin
    logic [511:0]  h, last, e1, e2;
    logic [1023:0] m;
    n_vec = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; chain_i = '0; block_i = '0;
    build_tables();

    // R10: exported starting chaining value
    for (int j = 0; j < 8; j++)
      check("R10 init chain word", 512'(sha512_pkg::INIT_CHAIN[j]), 512'(sqrt_frac(primes[j])));

    repeat (3) @(negedge clk);
    check("R1 reset busy", 512'(busy_o), 512'(0));
    check("R1 reset done", 512'(done_o), 512'(0));
    check("R1 reset digest", digest_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset outputs", {digest_o, busy_o, done_o}, '0);
    last = '0;

    // R3: all zeros, all ones (carry wrap), standard start with padded "abc"
    run_op('0, '0, 0, last, "zeros", e1); idle_after(e1, 2, "zeros"); last = e1;
    run_op('1, '1, 0, last, "ones", e1); idle_after(e1, 2, "ones"); last = e1;
    m = '0;
    m[63:0] = 64'h6162638000000000;
    m[1023:960] = 64'h18;
    run_op(sha512_pkg::INIT_CHAIN, m, 0, last, "abc", e1); idle_after(e1, 2, "abc"); last = e1;

    // R2: walking single word through every message position
    for (int j = 0; j < 16; j++) begin
      m = '0;
      m[64*j +: 64] = 64'h0123456789abcdef ^ 64'(j);
      run_op(sha512_pkg::INIT_CHAIN, m, 0, last, $sformatf("R2 msg word %0d", j), e1);
      last = e1;
    end
    // R2: walking single chaining word
    for (int j = 0; j < 8; j++) begin
      h = '0;
      h[64*j +: 64] = 64'hfedcba9876543210;
      run_op(h, '0, 0, last, $sformatf("R2 chain word %0d", j), e1);
      last = e1;
    end

    // R6: start pulsed while busy at first cycle, mid-run and in finalize
    run_op(rnd512(), {rnd512(), rnd512()}, 1, last, "R6 poke first", e1);
    idle_after(e1, 3, "R6 poke first"); last = e1;
    run_op(rnd512(), {rnd512(), rnd512()}, 40, last, "R6 poke mid", e1);
    idle_after(e1, 3, "R6 poke mid"); last = e1;
    run_op(rnd512(), {rnd512(), rnd512()}, LATENCY - 1, last, "R6 poke final", e1);
    idle_after(e1, 3, "R6 poke final"); last = e1;

    // R9: back-to-back operations started in the done cycle
    for (int k = 0; k < 6; k++) begin
      run_op(rnd512(), {rnd512(), rnd512()}, 0, last, $sformatf("R9 chain %0d", k), e2);
      last = e2;
    end
    idle_after(last, 4, "R9 tail");

    summary();
  end

endmodule